// File: doc/BRIEF.md
# Single-Step and Resume-Flag Sequencer

This block sits beside an instruction retirement interface and decides, one cycle at a time, which debug-related handler entry the core takes. It owns the trap flag (TF) and the resume flag (RF). It arms single-stepping when an instruction begins and takes the step trap when that instruction retires. It suppresses debug faults while RF is set. It raises a trap after a switch into a task whose trap bit is set. It orders an external interrupt behind a concurrent debug trap. For every handler entry it produces the flags image to be pushed, plus two cause bits that a status register can capture.

The core reports the start of an instruction, its successful completion together with its class, a non-debug fault, or a debug-fault request. At completion it also supplies the flags image loaded from memory and the trap bit of a new task. Each decision is registered: the selection, pushed image and cause bits are valid for exactly one cycle after the edge that sampled the event. Stack handling and descriptor loading stay outside the block.

Top module: `step_resume_ctl`

## Requirements
- R1: After reset, TF and RF are 0, the selection output is 0 (none), and the fault, cause and pushed-image outputs are 0.
- R2: A completing instruction takes a debug trap (selection 1, BS cause set) if and only if TF was 1 in the cycle that instruction started. An instruction that loads TF=1 while TF was 0 at its start does not trap. No trap is ever taken in a start cycle.
- R3: Every handler entry (selection not 0) leaves TF at 0. Completion of a software interrupt (class 4) clears TF, and the pushed image of any trap shows the TF value as it stood after the instruction.
- R4: When a debug trap is taken while the external interrupt request is high, the trap is selected first. In the following cycle, if the request is still high, the interrupt is selected (code 3) with TF=0 pushed. A lone interrupt at completion is selected directly.
- R5: Fault entries (selection 2 for ordinary faults, selection 1 with the fault output high for debug faults) push RF=1 and the TF value of the faulting instruction. Trap and interrupt entries push the RF value that stands after the completing instruction.
- R6: While RF is 1, a debug-fault request at instruction start is ignored. Ordinary faults and debug traps are still taken. While RF is 0, the same request produces a debug fault.
- R7: Successful completion of class 0 (other) or class 4 clears RF. Classes 1 (IRET), 2 (flags pop) and 3 (task-switching jump/call/interrupt) load TF and RF from the memory flags image.
- R8: An ordinary fault does not change RF, so a retried instruction that faults again keeps RF at 1 and keeps debug faults suppressed.
- R9: Completion of class 3 with the new task's trap bit set takes a debug trap with the BT cause set. A TF of 1 in that task's image produces a step trap only at completion of the task's first instruction.
- R10: The BS and BT cause outputs are high only together with selection 1 and the fault output low. The fault output is never high with selection 0 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_start | input | 1 | An instruction begins this cycle |
| insn_done | input | 1 | The current instruction completes successfully this cycle |
| insn_class | input | 3 | Class of the completing instruction: 0 other, 1 IRET, 2 flags pop, 3 task switch, 4 software interrupt |
| mem_tf | input | 1 | TF bit of the flags image loaded from memory |
| mem_rf | input | 1 | RF bit of the flags image loaded from memory |
| new_tbit | input | 1 | Trap bit of the task entered by a class-3 instruction |
| other_fault | input | 1 | A non-debug fault aborts the current instruction |
| dbg_fault_req | input | 1 | An instruction-address breakpoint matches the starting instruction |
| dbg_trap_req | input | 1 | A data breakpoint matched during the completing instruction |
| ext_irq | input | 1 | External interrupt request |
| exc_sel | output | 2 | Entry taken: 0 none, 1 debug, 2 ordinary fault, 3 interrupt |
| exc_fault | output | 1 | The entry is fault-class |
| push_tf | output | 1 | TF of the flags image to push |
| push_rf | output | 1 | RF of the flags image to push |
| tf | output | 1 | Current trap flag |
| rf | output | 1 | Current resume flag |
| stat_bs | output | 1 | Cause: single step |
| stat_bt | output | 1 | Cause: task-switch trap bit |

## Verification
The assertions check these relations on every cycle: TF is cleared by each entry, RF=1 is pushed on fault entries, a start-time debug request is suppressed under RF, RF is cleared by ordinary completions, the interrupt follows a trap that deferred it, and the cause bits are tied to debug-trap entries. The sweep goes further. It checks that TF is sampled at start and not at completion, that the memory image is loaded for each flag-loading class, that trap-bit and step causes combine correctly, and the exact values pushed for all combinations of class, loaded image, starting flags, data-breakpoint and interrupt request. Directed scenarios cover the fault-then-retry sequence under RF and debug faults with RF clear.

// File: rtl/srctl_pkg.sv
package srctl_pkg;

  typedef enum logic [2:0] {
    IC_OTHER   = 3'd0,
    IC_IRET    = 3'd1,
    IC_POPF    = 3'd2,
    IC_TSWITCH = 3'd3,
    IC_SWINT   = 3'd4
  } iclass_e;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_DEBUG = 2'd1,
    SEL_FAULT = 2'd2,
    SEL_IRQ   = 2'd3
  } esel_e;

  // True for classes whose completion reloads flags from memory.
  function automatic logic loads_image(iclass_e c);
    return (c == IC_IRET) || (c == IC_POPF) || (c == IC_TSWITCH);
  endfunction

  // Flags after successful completion: {tf, rf}.
  function automatic logic [1:0] retire_flags(iclass_e c, logic tf_cur,
                                              logic img_tf, logic img_rf);
    logic [1:0] r;
    if (loads_image(c))      r = {img_tf, img_rf};
    else if (c == IC_SWINT)  r = 2'b00;
    else                     r = {tf_cur, 1'b0};
    return r;
  endfunction

endpackage

// File: rtl/srctl_retire.sv
module srctl_retire
  import srctl_pkg::*;
(
  input  iclass_e cls,
  input  logic    tf_cur,
  input  logic    img_tf,
  input  logic    img_rf,
  input  logic    tbit,
  output logic    tf_ret,
  output logic    rf_ret,
  output logic    tbit_hit
);
  logic [1:0] fl;
  always_comb begin
    fl       = retire_flags(cls, tf_cur, img_tf, img_rf);
    tf_ret   = fl[1];
    rf_ret   = fl[0];
    tbit_hit = (cls == IC_TSWITCH) && tbit;
  end
endmodule

// File: rtl/srctl_arbiter.sv
module srctl_arbiter
  import srctl_pkg::*;
(
  input  logic  irq_follow,
  input  logic  fault,
  input  logic  start,
  input  logic  dbg_fault_req,
  input  logic  done,
  input  logic  step_armed,
  input  logic  tbit_hit,
  input  logic  dbg_trap_req,
  input  logic  ext_irq,
  input  logic  tf_cur,
  input  logic  rf_cur,
  input  logic  tf_ret,
  input  logic  rf_ret,
  output esel_e sel,
  output logic  is_fault,
  output logic  push_tf,
  output logic  push_rf,
  output logic  tf_nx,
  output logic  rf_nx,
  output logic  bs,
  output logic  bt,
  output logic  irq_chk_nx
);
  logic trap_any;
  assign trap_any = step_armed | tbit_hit | dbg_trap_req;

  always_comb begin
    sel        = SEL_NONE;
    is_fault   = 1'b0;
    push_tf    = 1'b0;
    push_rf    = 1'b0;
    tf_nx      = tf_cur;
    rf_nx      = rf_cur;
    bs         = 1'b0;
    bt         = 1'b0;
    irq_chk_nx = 1'b0;
    if (irq_follow) begin
      sel     = SEL_IRQ;
      push_tf = tf_cur;
      push_rf = rf_cur;
      tf_nx   = 1'b0;
    end else if (fault) begin
      sel      = SEL_FAULT;
      is_fault = 1'b1;
      push_tf  = tf_cur;
      push_rf  = 1'b1;
      tf_nx    = 1'b0;
    end else if (start && dbg_fault_req && !rf_cur) begin
      sel      = SEL_DEBUG;
      is_fault = 1'b1;
      push_tf  = tf_cur;
      push_rf  = 1'b1;
      tf_nx    = 1'b0;
    end else if (done) begin
      rf_nx = rf_ret;
      if (trap_any) begin
        sel        = SEL_DEBUG;
        push_tf    = tf_ret;
        push_rf    = rf_ret;
        tf_nx      = 1'b0;
        bs         = step_armed;
        bt         = tbit_hit;
        irq_chk_nx = ext_irq;
      end else if (ext_irq) begin
        sel     = SEL_IRQ;
        push_tf = tf_ret;
        push_rf = rf_ret;
        tf_nx   = 1'b0;
      end else begin
        tf_nx = tf_ret;
      end
    end
  end
endmodule

// File: rtl/step_resume_ctl.sv
module step_resume_ctl
  import srctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       insn_start,
  input  logic       insn_done,
  input  logic [2:0] insn_class,
  input  logic       mem_tf,
  input  logic       mem_rf,
  input  logic       new_tbit,
  input  logic       other_fault,
  input  logic       dbg_fault_req,
  input  logic       dbg_trap_req,
  input  logic       ext_irq,
  output logic [1:0] exc_sel,
  output logic       exc_fault,
  output logic       push_tf,
  output logic       push_rf,
  output logic       tf,
  output logic       rf,
  output logic       stat_bs,
  output logic       stat_bt
);
  logic  tf_q, rf_q, step_armed_q, irq_chk_q;
  esel_e sel_q;
  logic  fault_q, ptf_q, prf_q, bs_q, bt_q;

  // Named internal events
  logic  irq_follow;
  logic  tf_ret, rf_ret, tbit_hit;
  esel_e sel_c;
  logic  is_fault_c, ptf_c, prf_c, tf_nx, rf_nx, bs_c, bt_c, irq_chk_nx;

  assign irq_follow = irq_chk_q & ext_irq;

  srctl_retire u_retire (
    .cls      (iclass_e'(insn_class)),
    .tf_cur   (tf_q),
    .img_tf   (mem_tf),
    .img_rf   (mem_rf),
    .tbit     (new_tbit),
    .tf_ret   (tf_ret),
    .rf_ret   (rf_ret),
    .tbit_hit (tbit_hit)
  );

  srctl_arbiter u_arb (
    .irq_follow    (irq_follow),
    .fault         (other_fault),
    .start         (insn_start),
    .dbg_fault_req (dbg_fault_req),
    .done          (insn_done),
    .step_armed    (step_armed_q),
    .tbit_hit      (tbit_hit),
    .dbg_trap_req  (dbg_trap_req),
    .ext_irq       (ext_irq),
    .tf_cur        (tf_q),
    .rf_cur        (rf_q),
    .tf_ret        (tf_ret),
    .rf_ret        (rf_ret),
    .sel           (sel_c),
    .is_fault      (is_fault_c),
    .push_tf       (ptf_c),
    .push_rf       (prf_c),
    .tf_nx         (tf_nx),
    .rf_nx         (rf_nx),
    .bs            (bs_c),
    .bt            (bt_c),
    .irq_chk_nx    (irq_chk_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tf_q         <= 1'b0;
      rf_q         <= 1'b0;
      step_armed_q <= 1'b0;
      irq_chk_q    <= 1'b0;
      sel_q        <= SEL_NONE;
      fault_q      <= 1'b0;
      ptf_q        <= 1'b0;
      prf_q        <= 1'b0;
      bs_q         <= 1'b0;
      bt_q         <= 1'b0;
    end else begin
      tf_q      <= tf_nx;
      rf_q      <= rf_nx;
      irq_chk_q <= irq_chk_nx;
      sel_q     <= sel_c;
      fault_q   <= is_fault_c;
      ptf_q     <= ptf_c;
      prf_q     <= prf_c;
      bs_q      <= bs_c;
      bt_q      <= bt_c;
      // TF is captured when the instruction begins, not when it ends.
      if (insn_start && sel_c == SEL_NONE) step_armed_q <= tf_q;
      else if (insn_done || other_fault || sel_c != SEL_NONE) step_armed_q <= 1'b0;
    end
  end

  assign exc_sel   = sel_q;
  assign exc_fault = fault_q;
  assign push_tf   = ptf_q;
  assign push_rf   = prf_q;
  assign tf        = tf_q;
  assign rf        = rf_q;
  assign stat_bs   = bs_q;
  assign stat_bt   = bt_q;

  AST_TF_CLEAR_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != SEL_NONE) |-> !tf_q); // R3
  AST_STEP_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    bs_q |-> $past(step_armed_q)); // R2
  AST_FAULT_PUSHES_RF: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |-> prf_q); // R5
  AST_RF_MASKS_DBG_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_q && insn_start && dbg_fault_req && !other_fault && !irq_follow)
    |=> (sel_q == SEL_NONE)); // R6
  AST_PLAIN_CLEARS_RF: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && insn_class == IC_OTHER && !other_fault && !irq_follow)
    |=> !rf_q); // R7
  AST_IRQ_AFTER_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_chk_q && ext_irq) |=> (sel_q == SEL_IRQ)); // R4
  AST_TBIT_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && insn_class == IC_TSWITCH && new_tbit && !other_fault && !irq_follow)
    |=> (bt_q && sel_q == SEL_DEBUG)); // R9
  AST_CAUSE_ONLY_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
    (bs_q || bt_q) |-> (sel_q == SEL_DEBUG && !fault_q)); // R10
endmodule

// File: tb/step_resume_ctl_test.sv
module step_resume_ctl_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic insn_start, insn_done, mem_tf, mem_rf, new_tbit;
  logic other_fault, dbg_fault_req, dbg_trap_req, ext_irq;
  logic [2:0] insn_class;
  logic [1:0] exc_sel;
  logic exc_fault, push_tf, push_rf, tf, rf, stat_bs, stat_bt;

  int errors = 0;
  int checks = 0;

  always #(CLK_P/2) clk = ~clk;

  step_resume_ctl uut (
    .clk(clk), .rst_n(rst_n), .insn_start(insn_start), .insn_done(insn_done),
    .insn_class(insn_class), .mem_tf(mem_tf), .mem_rf(mem_rf), .new_tbit(new_tbit),
    .other_fault(other_fault), .dbg_fault_req(dbg_fault_req), .dbg_trap_req(dbg_trap_req),
    .ext_irq(ext_irq), .exc_sel(exc_sel), .exc_fault(exc_fault), .push_tf(push_tf),
    .push_rf(push_rf), .tf(tf), .rf(rf), .stat_bs(stat_bs), .stat_bt(stat_bt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    insn_start = 0; insn_done = 0; insn_class = 0; mem_tf = 0; mem_rf = 0;
    new_tbit = 0; other_fault = 0; dbg_fault_req = 0; dbg_trap_req = 0; ext_irq = 0;
  endtask

  // Inputs change 1 time unit after a rising edge; outputs sampled there too.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    tick();
    tick();
    rst_n = 1;
  endtask

  // Bring TF/RF to the requested values with a flags-pop from a clean reset.
  task automatic setup_flags(input logic t0, input logic r0);
    do_reset();
    insn_start = 1; tick(); insn_start = 0;
    insn_done = 1; insn_class = 3'd2; mem_tf = t0; mem_rf = r0;
    tick(); idle();
    chk("R2 pop setting TF does not trap", exc_sel, 0);
    chk("R7 pop loads TF", tf, t0);
    chk("R7 pop loads RF", rf, r0);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 tf", tf, 0);
    chk("R1 rf", rf, 0);
    chk("R1 sel", exc_sel, 0);
    chk("R1 fault/push/cause", {exc_fault, push_tf, push_rf, stat_bs, stat_bt}, 0);

    // Sweep: starting flags x class x memory image x trap bit x data trap x irq
    for (int t0 = 0; t0 < 2; t0++)
    for (int r0 = 0; r0 < 2; r0++)
    for (int c = 0; c < 5; c++)
    for (int mt = 0; mt < 2; mt++)
    for (int mr = 0; mr < 2; mr++)
    for (int tb = 0; tb < 2; tb++)
    for (int dt = 0; dt < 2; dt++)
    for (int ei = 0; ei < 2; ei++) begin
      logic ld, tr, hit;
      int tfr, rfr;
      setup_flags(t0[0], r0[0]);
      insn_start = 1; tick(); insn_start = 0;
      chk("R2 no trap at start", exc_sel, 0);
      ld  = (c >= 1 && c <= 3);
      tfr = ld ? mt : ((c == 4) ? 0 : t0);
      rfr = ld ? mr : 0;
      hit = (c == 3) && tb[0];
      tr  = t0[0] | hit | dt[0];
      insn_done = 1; insn_class = c[2:0]; mem_tf = mt[0]; mem_rf = mr[0];
      new_tbit = tb[0]; dbg_trap_req = dt[0]; ext_irq = ei[0];
      tick(); idle(); ext_irq = ei[0];
      if (tr) begin
        chk("R2 R9 debug trap taken", exc_sel, 1);
        chk("R10 trap not fault-class", exc_fault, 0);
        chk("R2 BS cause", stat_bs, t0);
        chk("R9 BT cause", stat_bt, hit);
        chk("R3 pushed TF after insn", push_tf, tfr);
        chk("R5 trap pushes retired RF", push_rf, rfr);
        chk("R3 TF cleared on entry", tf, 0);
      end else if (ei) begin
        chk("R4 lone irq selected", exc_sel, 3);
        chk("R3 irq push TF", push_tf, tfr);
        chk("R5 irq push RF", push_rf, rfr);
        chk("R3 TF cleared on irq entry", tf, 0);
        chk("R10 no cause on irq", {stat_bs, stat_bt}, 0);
      end else begin
        chk("R2 no trap", exc_sel, 0);
        chk("R3 R7 TF after completion", tf, tfr);
      end
      chk("R7 RF after completion", rf, rfr);
      tick(); idle();
      chk("R4 follow-up selection", exc_sel, (tr && ei) ? 3 : 0);
      if (tr && ei) begin
        chk("R4 follow-up pushes TF=0", push_tf, 0);
        chk("R4 follow-up keeps TF=0", tf, 0);
      end
    end

    // R9: task switch with trap bit and TF in image; step only after first insn
    do_reset();
    insn_start = 1; tick(); insn_start = 0;
    insn_done = 1; insn_class = 3'd3; mem_tf = 1; new_tbit = 1; tick(); idle();
    chk("R9 BT trap before first insn", {exc_sel, stat_bt, stat_bs}, {2'd1, 1'b1, 1'b0});
    chk("R9 image TF pushed", push_tf, 1);
    insn_start = 1; insn_class = 3'd1; tick(); insn_start = 0; // not used at start
    idle();
    insn_done = 1; insn_class = 3'd1; mem_tf = 1; mem_rf = 0; tick(); idle();
    chk("R9 IRET back, no step (TF was 0 at start)", exc_sel, 0);
    insn_start = 1; tick(); insn_start = 0;
    insn_done = 1; tick(); idle();
    chk("R9 step after first insn of task", {exc_sel, stat_bs}, {2'd1, 1'b1});

    // R6: debug fault with RF clear
    setup_flags(1'b1, 1'b0);
    insn_start = 1; dbg_fault_req = 1; tick(); idle();
    chk("R6 debug fault with RF=0", {exc_sel, exc_fault}, {2'd1, 1'b1});
    chk("R5 debug fault pushes RF=1", push_rf, 1);
    chk("R5 debug fault pushes TF", push_tf, 1);
    chk("R10 no cause on debug fault", {stat_bs, stat_bt}, 0);
    chk("R3 TF cleared by debug fault", tf, 0);

    // R6 R8: RF set; request ignored, fault taken, RF kept, retry still masked
    setup_flags(1'b0, 1'b1);
    insn_start = 1; dbg_fault_req = 1; tick(); idle();
    chk("R6 debug fault ignored under RF", exc_sel, 0);
    other_fault = 1; tick(); idle();
    chk("R5 ordinary fault selected", {exc_sel, exc_fault}, {2'd2, 1'b1});
    chk("R5 ordinary fault pushes RF=1", push_rf, 1);
    chk("R8 RF kept across fault", rf, 1);
    insn_start = 1; dbg_fault_req = 1; tick(); idle();
    chk("R8 retry still masks debug fault", exc_sel, 0);
    insn_done = 1; dbg_trap_req = 1; tick(); idle();
    chk("R6 debug trap still taken under RF", exc_sel, 1);
    chk("R7 RF cleared by completion", rf, 0);
    insn_start = 1; dbg_fault_req = 1; tick(); idle();
    chk("R6 debug fault taken once RF clear", {exc_sel, exc_fault}, {2'd1, 1'b1});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule